// File: doc/BRIEF.md
# Power-Off Acknowledge Timeout Monitor

This block sits in a PCI Express root port. It decides when power may be taken away from the devices below the port. Power management logic elsewhere broadcasts a turn-off message and then pulses `turnoff_done_i`. From that point a cycle counter runs against a limit that software has programmed. Three things can then happen. An acknowledge message from downstream arrives (`ack_msg_i`), the link reports that it has reached the L2/L3 Ready power state (`l23_ready_i`), or the counter runs out. Each of these sets its own sticky status flag.

The flags feed a registered `safe_off_o` output. An acknowledge or a timeout permits power removal at once. The L2/L3 Ready flag permits it only after a fixed settling delay of about 100 ns, converted to core clock cycles.

Software reaches two words through a simple single-cycle register bus. One word holds the timeout limit. The other holds the status flags, which software clears by writing one to each flag.

Top module: `pwroff_ack_watch`

## Requirements
- R1: Word address 0 holds the timeout limit as a 22-bit count in bits 21..0, written by a bus write to that address. Bits 31..22 always read as zero.
- R2: The timeout limit is a number of core clock cycles, equal to the desired time in microseconds times the clock in MHz. If a broadcast-done pulse is sampled at edge k and no acknowledge follows, status bit 2 (timeout) sets at edge k+limit.
- R3: An acknowledge pulse sets status bit 0 (acknowledge) at the edge that samples it. It also stops a running count, so a later timeout does not set.
- R4: An acknowledge sampled at the same edge at which the count would expire is treated as an acknowledge: bit 0 sets and bit 2 stays clear.
- R5: The L2/L3 Ready level sets status bit 1 at the edge that samples it high.
- R6: The status word sits at word address 1. Each flag is sticky and clears only when a bus write to that address has a 1 in that flag's bit. Writing 0 leaves it unchanged, and a set in the same cycle wins over a clear.
- R7: `safe_off_o` is high in the same cycle as status bit 0 or bit 2, or SETTLE_CYC cycles after status bit 1 sets, where SETTLE_CYC is 5 by default (100 ns at 50 MHz). It is low when none of these holds.
- R8: After reset the timeout word, the status word and `safe_off_o` are all zero.
- R9: A timeout limit of zero disables the timer, and status bit 2 never sets.
- R10: A new broadcast-done pulse restarts the count from zero, even while a count is already running.
- R11: Read data appears on `bus_rdata_o` on the clock edge after the one that samples the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| turnoff_done_i | input | 1 | One-cycle pulse at the end of the turn-off broadcast |
| ack_msg_i | input | 1 | One-cycle pulse when an acknowledge message is received |
| l23_ready_i | input | 1 | High while the link is in L2/L3 Ready |
| bus_sel_i | input | 1 | Register access request |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word address (0 timeout limit, 1 status) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| safe_off_o | output | 1 | Downstream power may be removed |

## Verification
Each result is due a fixed number of edges after its stimulus:
- A timeout flag and `safe_off_o` are due exactly `limit` edges after the edge that samples the broadcast pulse.
- An acknowledge or a clear takes effect at the edge that samples it.
- The L2/L3 path raises `safe_off_o` SETTLE_CYC edges after its flag sets.
- Read data is due one edge after the request.

The driver changes inputs 2 ns after a rising edge and samples `safe_off_o` at the same offset. That spot is one cycle before the due edge and again just after it, so an early or a late response is caught. Read results are queued with their expected value when the request is issued. A monitor then compares them on the falling edge after the sampling edge.

// File: rtl/pwroff_pkg.sv
package pwroff_pkg;
  localparam int unsigned ST_ACK  = 0;
  localparam int unsigned ST_L23  = 1;
  localparam int unsigned ST_TMO  = 2;
  localparam int unsigned ST_W    = 3;
  localparam int unsigned REG_TMO  = 0;
  localparam int unsigned REG_STAT = 1;

  // bit 2 timeout, bit 1 L2/L3 ready, bit 0 acknowledge
  typedef struct packed {
    logic tmo;
    logic l23;
    logic ack;
  } stat_t;
endpackage

// File: rtl/pwroff_regs.sv
module pwroff_regs
  import pwroff_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned TMO_W  = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  stat_t             stat,
  output logic [DATA_W-1:0] rdata,
  output logic [TMO_W-1:0]  tmo_lim,
  output stat_t             clr
);
  localparam int unsigned PAD_W = DATA_W - TMO_W;

  logic hit_tmo, hit_stat;

  assign hit_tmo  = sel && (addr == ADDR_W'(REG_TMO));
  assign hit_stat = sel && (addr == ADDR_W'(REG_STAT));

  always_comb begin
    clr = '0;
    if (hit_stat && wr) clr = stat_t'(wdata[ST_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_lim <= '0;
      rdata   <= '0;
    end else begin
      if (hit_tmo && wr) tmo_lim <= wdata[TMO_W-1:0];
      if (sel && !wr) begin
        if (hit_tmo)       rdata <= {{PAD_W{1'b0}}, tmo_lim};
        else if (hit_stat) rdata <= {{(DATA_W-ST_W){1'b0}}, stat};
        else               rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/pwroff_timer.sv
module pwroff_timer #(
  parameter int unsigned TMO_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             ack,
  input  logic [TMO_W-1:0] lim,
  output logic             run,
  output logic             expire
);
  logic [TMO_W-1:0] cnt_q;
  logic             last;

  assign last   = (TMO_W'(cnt_q + 1'b1) == lim);
  assign expire = run && last && (lim != '0) && !ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      cnt_q <= '0;
    end else if (ack) begin
      run <= 1'b0;
    end else if (start) begin
      run   <= (lim != '0);
      cnt_q <= '0;
    end else if (run) begin
      if (last || lim == '0) run <= 1'b0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwroff_status.sv
module pwroff_status
  import pwroff_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 5
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  ack,
  input  logic  l23,
  input  logic  expire,
  input  stat_t clr,
  output stat_t stat_q,
  output logic  safe_q
);
  localparam int unsigned SC_W = $clog2(SETTLE_CYC + 1);
  localparam logic [SC_W-1:0] SC_END = SC_W'(SETTLE_CYC);

  stat_t           set_v, stat_n;
  logic [SC_W-1:0] sc_q, sc_n;
  logic            safe_n;

  always_comb begin
    set_v     = '0;
    set_v.ack = ack;
    set_v.l23 = l23;
    set_v.tmo = expire;
    stat_n    = (stat_q & ~clr) | set_v;
    if (!stat_n.l23 || !stat_q.l23) sc_n = '0;
    else if (sc_q == SC_END)        sc_n = sc_q;
    else                            sc_n = sc_q + 1'b1;
    safe_n = stat_n.ack || stat_n.tmo || (stat_n.l23 && sc_n == SC_END);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      sc_q   <= '0;
      safe_q <= 1'b0;
    end else begin
      stat_q <= stat_n;
      sc_q   <= sc_n;
      safe_q <= safe_n;
    end
  end
endmodule

// File: rtl/pwroff_ack_watch.sv
module pwroff_ack_watch
  import pwroff_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned TMO_W     = 22,
  parameter int unsigned CORE_MHZ  = 50,
  parameter int unsigned SETTLE_NS = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              turnoff_done_i,
  input  logic              ack_msg_i,
  input  logic              l23_ready_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              safe_off_o
);
  localparam int unsigned SETTLE_RAW = (SETTLE_NS * CORE_MHZ + 999) / 1000;
  localparam int unsigned SETTLE_CYC = (SETTLE_RAW == 0) ? 1 : SETTLE_RAW;

  stat_t            stat_q, clr;
  logic [ST_W-1:0]  stat_vec;
  logic [TMO_W-1:0] tmo_lim;
  logic             tmo_run, tmo_expire;

  assign stat_vec = stat_q;

  pwroff_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TMO_W(TMO_W)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel_i), .wr(bus_wr_i), .addr(bus_addr_i),
    .wdata(bus_wdata_i), .stat(stat_q), .rdata(bus_rdata_o),
    .tmo_lim(tmo_lim), .clr(clr)
  );

  pwroff_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst(rst), .start(turnoff_done_i), .ack(ack_msg_i),
    .lim(tmo_lim), .run(tmo_run), .expire(tmo_expire)
  );

  pwroff_status #(.SETTLE_CYC(SETTLE_CYC)) u_status (
    .clk(clk), .rst(rst), .ack(ack_msg_i), .l23(l23_ready_i),
    .expire(tmo_expire), .clr(clr), .stat_q(stat_q), .safe_q(safe_off_o)
  );
endmodule

// File: rtl/pwroff_ack_chk.sv
module pwroff_ack_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned TMO_W  = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              ack_msg_i,
  input logic              l23_ready_i,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              safe_off_o,
  input logic [2:0]        stat_vec,
  input logic              tmo_run,
  input logic [TMO_W-1:0]  tmo_lim
);
  logic [2:0] clr_m, keep_m;

  assign clr_m  = (bus_sel_i && bus_wr_i && bus_addr_i == ADDR_W'(1)) ? bus_wdata_i[2:0] : 3'b000;
  assign keep_m = stat_vec & ~clr_m;

  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (|stat_vec) |=> ((stat_vec & $past(keep_m)) == $past(keep_m))); // R6

  AST_ACK_SETS: assert property (@(posedge clk) disable iff (rst)
    ack_msg_i |=> stat_vec[0]); // R3

  AST_L23_SETS: assert property (@(posedge clk) disable iff (rst)
    l23_ready_i |=> stat_vec[1]); // R5

  AST_TMO_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_vec[2]) |-> ($past(tmo_run) && !$past(ack_msg_i))); // R4

  AST_TMO_NONZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_vec[2]) |-> ($past(tmo_lim) != '0)); // R9

  AST_SAFE_FAST: assert property (@(posedge clk) disable iff (rst)
    (stat_vec[0] || stat_vec[2]) |-> safe_off_o); // R7

  AST_SAFE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    safe_off_o |-> (|stat_vec)); // R7

  AST_RDATA_PAD: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel_i && !bus_wr_i && bus_addr_i == '0) |-> (bus_rdata_o[DATA_W-1:TMO_W] == '0)); // R1
endmodule

bind pwroff_ack_watch pwroff_ack_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TMO_W(TMO_W)) u_chk (
  .clk(clk), .rst(rst), .ack_msg_i(ack_msg_i), .l23_ready_i(l23_ready_i),
  .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .safe_off_o(safe_off_o),
  .stat_vec(stat_vec), .tmo_run(tmo_run), .tmo_lim(tmo_lim)
);

// File: tb/sim_pwroff_ack_watch.sv
`timescale 1ns/1ps
module sim_pwroff_ack_watch;
  localparam int LIM = 10;
  localparam int SC  = 5;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bcast = 1'b0, ack = 1'b0, l23 = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        safe;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  bit          rd_pend = 1'b0;
  exp_t        sb[$];

  always #10 clk = ~clk;

  pwroff_ack_watch u0 (
    .clk(clk), .rst(rst), .turnoff_done_i(bcast), .ack_msg_i(ack),
    .l23_ready_i(l23), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .safe_off_o(safe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    tick(1);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb.push_back(e);
    sel = 1'b1; wr = 1'b0; addr = a;
    tick(1);
    sel = 1'b0;
  endtask

  task automatic pulse_bcast();
    bcast = 1'b1; tick(1); bcast = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  // monitor: read result is due one edge after the request edge (R11)
  always @(negedge clk) begin
    if (rd_pend) begin
      exp_t e;
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11: unexpected read result %h expected none", rdata);
      end else begin
        e = sb.pop_front();
        check(e.tag, rdata, e.val);
      end
    end
    rd_pend = sel && !wr;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R8 reset state
    check("R8 safe after reset", {31'd0, safe}, 32'd0);
    bus_read(2'd0, 32'h0, "R8 timeout word reset");
    bus_read(2'd1, 32'h0, "R8 status word reset");

    // R1 width of the limit field
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd0, 32'h003F_FFFF, "R1 limit upper bits zero");
    bus_write(2'd0, LIM);
    bus_read(2'd0, LIM, "R1 limit readback");

    // R2 timeout after LIM edges
    pulse_bcast();
    tick(LIM - 1);
    check("R2 safe low before expiry", {31'd0, safe}, 32'd0);
    tick(1);
    check("R2 safe at expiry", {31'd0, safe}, 32'd1);
    bus_read(2'd1, 32'h4, "R2 timeout flag");
    // R6 write of zero keeps, write of one clears
    bus_write(2'd1, 32'h0);
    bus_read(2'd1, 32'h4, "R6 write zero ignored");
    bus_write(2'd1, 32'h4);
    check("R6 safe after clear", {31'd0, safe}, 32'd0);
    bus_read(2'd1, 32'h0, "R6 flag cleared");

    // R3 acknowledge before expiry stops the count
    pulse_bcast();
    tick(3);
    pulse_ack();
    check("R3 safe after ack", {31'd0, safe}, 32'd1);
    tick(LIM + 4);
    bus_read(2'd1, 32'h1, "R3 ack only, no timeout");
    bus_write(2'd1, 32'h1);

    // R4 acknowledge on the expiry edge
    pulse_bcast();
    tick(LIM - 1);
    pulse_ack();
    tick(3);
    bus_read(2'd1, 32'h1, "R4 ack wins the race");
    bus_write(2'd1, 32'h7);

    // R10 restart on a second pulse
    pulse_bcast();
    tick(4);
    pulse_bcast();
    tick(LIM - 1);
    check("R10 no expiry from first pulse", {31'd0, safe}, 32'd0);
    tick(1);
    check("R10 expiry from second pulse", {31'd0, safe}, 32'd1);
    bus_write(2'd1, 32'h4);

    // R9 zero limit disables
    bus_write(2'd0, 32'h0);
    pulse_bcast();
    tick(LIM * 3);
    check("R9 safe stays low", {31'd0, safe}, 32'd0);
    bus_read(2'd1, 32'h0, "R9 no timeout flag");

    // R5 and R7 L2/L3 path with settling delay
    l23 = 1'b1; tick(1); l23 = 1'b0;
    tick(SC - 1);
    check("R7 safe low during settle", {31'd0, safe}, 32'd0);
    tick(1);
    check("R7 safe after settle", {31'd0, safe}, 32'd1);
    bus_read(2'd1, 32'h2, "R5 L2/L3 flag");
    bus_write(2'd1, 32'h2);
    check("R7 safe drops on clear", {31'd0, safe}, 32'd0);
    bus_read(2'd1, 32'h0, "R6 L2/L3 flag cleared");

    tick(3);
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R11: actual %0d reads pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule